// File: doc/BRIEF.md
# Keyed Flash Erase Command Controller

This block sits on the special-function-register write bus of an 8-bit microcontroller. It turns a short, guarded sequence of register writes into one erase request to a flash macro. Firmware first arms an erase. It does this either by writing the target page number or by setting the whole-array enable bit. It then writes a key byte to the command register. The controller checks the key, the arming and, for a whole-array erase, the debug-port enable. Only then does it pulse exactly one request line for a single cycle. It reports busy until the flash macro signals completion.

Arming is single-use. Any accepted erase clears both arm flags, so every new cycle needs fresh setup writes. A command that is rejected changes nothing. This covers a wrong key, a missing arm, the debug port being off, or the controller being busy. The block also holds the program-write-enable bit. That bit redirects the next external-data-move write into program flash. It clears itself after that one byte, and it cannot be changed while interrupts are globally enabled.

All control and status pins are plain levels or one-cycle strobes. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure. A register write is taken in the cycle where `sfr_we` is high.

Top module: `flash_erase_ctrl`

## Requirements
- R1: A write of 0x55 to the command address (0x40) while idle, with the page armed, raises `page_erase_req` for exactly one cycle, in the cycle after the write. During that cycle `erase_page` shows the stored page number.
- R2: A write of 0xAA to the command address while idle, with the whole-array enable armed and `dbg_port_en` high, raises `mass_erase_req` for exactly one cycle, in the cycle after the write.
- R3: A command byte other than 0x55 or 0xAA raises no request and leaves every arm flag and register unchanged.
- R4: A 0x55 command is rejected if no write to the page address (0x41) has occurred since the last accepted erase or reset. That register stores data bits [6:0] as the page number (0 to 127) and ignores bit 7.
- R5: A 0xAA command is rejected when bit 1 of the control register (0x42) was not last written as 1, or when `dbg_port_en` is low. A rejection leaves the arm in place.
- R6: Once an erase is accepted, both arm flags are cleared. A repeated key with no new setup write is rejected.
- R7: `busy` rises together with the request and stays high until `flash_done`. Key writes made while busy are ignored and do not consume arming.
- R8: Bit 0 of a control-register write sets or clears `prog_redirect` only when `irq_global_en` is low. Otherwise the bit keeps its value.
- R9: `prog_redirect` returns to 0 in the cycle after an `xmove_wr` strobe taken while it was 1.
- R10: After reset, `busy`, both requests and `prog_redirect` are 0, `erase_page` is 0, and no arm is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sfr_we | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Register write address |
| sfr_wdata | input | 8 | Register write data |
| dbg_port_en | input | 1 | Debug port enabled; required for a whole-array erase |
| irq_global_en | input | 1 | Global interrupt enable; blocks changes to the program-write bit |
| xmove_wr | input | 1 | External-data-move write strobe |
| flash_done | input | 1 | Flash macro reports that the erase has finished |
| page_erase_req | output | 1 | One-cycle page-erase request |
| mass_erase_req | output | 1 | One-cycle whole-array erase request |
| erase_page | output | 7 | Stored page number |
| busy | output | 1 | Erase in progress |
| prog_redirect | output | 1 | Next data-move write goes to program flash |

## Verification
The command path is driven with keyed sequences. These include an armed page erase, a wrong key between the arm and a valid key, a repeated key after completion, a whole-array erase with the debug port off and then on, and a page key with no arm at all. Together they separate key matching from the arming check, and they separate arm consumption from rejection, which must leave the arm in place. Directed cases cover the 7-bit page field with bit 7 set and key writes made while busy. They also cover the interrupt-enable interlock on the program-write bit and its self-clear after a data-move write.

// File: rtl/fec_pkg.sv
package fec_pkg;
  localparam logic [7:0] KEY_PAGE = 8'h55;
  localparam logic [7:0] KEY_MASS = 8'hAA;
  typedef enum logic [1:0] {ER_NONE = 2'd0, ER_PAGE = 2'd1, ER_MASS = 2'd2} erase_kind_e;
endpackage

// File: rtl/fec_key_decode.sv
module fec_key_decode
  import fec_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] ADDR_CMD = 8'h40
) (
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          page_armed,
  input  logic          mass_armed,
  input  logic          dbg_en,
  input  logic          busy,
  output erase_kind_e   kind
);
  logic cmd_hit;
  assign cmd_hit = we && (addr == ADDR_CMD) && !busy;

  always_comb begin
    kind = ER_NONE;
    if (cmd_hit) begin
      if (wdata == KEY_PAGE && page_armed)
        kind = ER_PAGE;
      else if (wdata == KEY_MASS && mass_armed && dbg_en)
        kind = ER_MASS;
    end
  end
endmodule

// File: rtl/fec_setup_regs.sv
module fec_setup_regs #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int PAGE_W = 7,
  parameter logic [AW-1:0] ADDR_PAGE = 8'h41,
  parameter logic [AW-1:0] ADDR_CTRL = 8'h42,
  parameter int PWE_BIT = 0,
  parameter int MEE_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  input  logic              irq_en,
  input  logic              xmove_wr,
  input  logic              consume,
  output logic [PAGE_W-1:0] page_q,
  output logic              page_armed,
  output logic              mass_armed,
  output logic              pwe_q
);
  logic page_wr, ctrl_wr;
  assign page_wr = we && (addr == ADDR_PAGE);
  assign ctrl_wr = we && (addr == ADDR_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q     <= '0;
      page_armed <= 1'b0;
      mass_armed <= 1'b0;
    end else if (consume) begin
      page_armed <= 1'b0;
      mass_armed <= 1'b0;
    end else begin
      if (page_wr) begin
        page_q     <= wdata[PAGE_W-1:0];
        page_armed <= 1'b1;
      end
      if (ctrl_wr)
        mass_armed <= wdata[MEE_BIT];
    end
  end

  // Auto-clear after one data-move byte takes priority over a same-cycle write.
  always_ff @(posedge clk) begin
    if (!rst_n)
      pwe_q <= 1'b0;
    else if (pwe_q && xmove_wr)
      pwe_q <= 1'b0;
    else if (ctrl_wr && !irq_en)
      pwe_q <= wdata[PWE_BIT];
  end
endmodule

// File: rtl/fec_sequencer.sv
module fec_sequencer
  import fec_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  erase_kind_e kind,
  input  logic        done,
  output logic        page_req,
  output logic        mass_req,
  output logic        busy
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_req <= 1'b0;
      mass_req <= 1'b0;
      busy     <= 1'b0;
    end else begin
      page_req <= (kind == ER_PAGE);
      mass_req <= (kind == ER_MASS);
      if (kind != ER_NONE)
        busy <= 1'b1;
      else if (done)
        busy <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
  import fec_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int PAGE_W = 7,
  parameter logic [AW-1:0] ADDR_CMD  = 8'h40,
  parameter logic [AW-1:0] ADDR_PAGE = 8'h41,
  parameter logic [AW-1:0] ADDR_CTRL = 8'h42
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sfr_we,
  input  logic [AW-1:0]     sfr_addr,
  input  logic [DW-1:0]     sfr_wdata,
  input  logic              dbg_port_en,
  input  logic              irq_global_en,
  input  logic              xmove_wr,
  input  logic              flash_done,
  output logic              page_erase_req,
  output logic              mass_erase_req,
  output logic [PAGE_W-1:0] erase_page,
  output logic              busy,
  output logic              prog_redirect
);
  erase_kind_e kind;
  logic page_armed, mass_armed;

  fec_setup_regs #(.AW(AW), .DW(DW), .PAGE_W(PAGE_W),
                   .ADDR_PAGE(ADDR_PAGE), .ADDR_CTRL(ADDR_CTRL)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(sfr_we), .addr(sfr_addr), .wdata(sfr_wdata),
    .irq_en(irq_global_en), .xmove_wr(xmove_wr), .consume(kind != ER_NONE),
    .page_q(erase_page), .page_armed(page_armed), .mass_armed(mass_armed),
    .pwe_q(prog_redirect)
  );

  fec_key_decode #(.AW(AW), .DW(DW), .ADDR_CMD(ADDR_CMD)) u_dec (
    .we(sfr_we), .addr(sfr_addr), .wdata(sfr_wdata),
    .page_armed(page_armed), .mass_armed(mass_armed),
    .dbg_en(dbg_port_en), .busy(busy), .kind(kind)
  );

  fec_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .kind(kind), .done(flash_done),
    .page_req(page_erase_req), .mass_req(mass_erase_req), .busy(busy)
  );
endmodule

// File: rtl/fec_checker.sv
module fec_checker #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] ADDR_CMD = 8'h40
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sfr_we,
  input logic [AW-1:0] sfr_addr,
  input logic [DW-1:0] sfr_wdata,
  input logic          dbg_port_en,
  input logic          irq_global_en,
  input logic          xmove_wr,
  input logic          page_erase_req,
  input logic          mass_erase_req,
  input logic          busy,
  input logic          prog_redirect
);
  assert_req_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({page_erase_req, mass_erase_req}));

  assert_page_key_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(page_erase_req) |-> $past(sfr_we && sfr_addr == ADDR_CMD && sfr_wdata == 8'h55));

  assert_mass_dbg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mass_erase_req) |-> $past(dbg_port_en && sfr_we && sfr_wdata == 8'hAA));

  assert_req_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (page_erase_req || mass_erase_req) |=> !(page_erase_req || mass_erase_req));

  assert_busy_with_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (page_erase_req || mass_erase_req) |-> busy);

  assert_no_req_when_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !(page_erase_req || mass_erase_req));

  assert_pwe_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_redirect) |-> !$past(irq_global_en));

  assert_pwe_selfclear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_redirect && xmove_wr) |=> !prog_redirect);
endmodule

bind flash_erase_ctrl fec_checker #(.AW(AW), .DW(DW), .ADDR_CMD(ADDR_CMD)) u_fec_checker (
  .clk(clk), .rst_n(rst_n), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
  .sfr_wdata(sfr_wdata), .dbg_port_en(dbg_port_en), .irq_global_en(irq_global_en),
  .xmove_wr(xmove_wr), .page_erase_req(page_erase_req),
  .mass_erase_req(mass_erase_req), .busy(busy), .prog_redirect(prog_redirect)
);

// File: tb/test_flash_erase_ctrl.sv
module test_flash_erase_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sfr_we = 1'b0;
  logic [7:0] sfr_addr = '0;
  logic [7:0] sfr_wdata = '0;
  logic dbg_port_en = 1'b0;
  logic irq_global_en = 1'b0;
  logic xmove_wr = 1'b0;
  logic flash_done = 1'b0;
  logic page_erase_req, mass_erase_req, busy, prog_redirect;
  logic [6:0] erase_page;

  int n_tests = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  flash_erase_ctrl i_flash_erase_ctrl (
    .clk(clk), .rst_n(rst_n), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .dbg_port_en(dbg_port_en), .irq_global_en(irq_global_en),
    .xmove_wr(xmove_wr), .flash_done(flash_done),
    .page_erase_req(page_erase_req), .mass_erase_req(mass_erase_req),
    .erase_page(erase_page), .busy(busy), .prog_redirect(prog_redirect)
  );

  localparam logic [7:0] A_CMD = 8'h40, A_PAGE = 8'h41, A_CTRL = 8'h42;

  // {addr, data, dbg, done_after, exp_page_req, exp_mass_req}
  localparam int NV = 9;
  localparam logic [19:0] VEC [NV] = '{
    {A_PAGE, 8'h05, 1'b0, 1'b0, 1'b0, 1'b0},  // arm page
    {A_CMD,  8'h33, 1'b0, 1'b0, 1'b0, 1'b0},  // R3 wrong key
    {A_CMD,  8'h55, 1'b0, 1'b1, 1'b1, 1'b0},  // R1 / R3 arm survived
    {A_CMD,  8'h55, 1'b0, 1'b0, 1'b0, 1'b0},  // R6 arm consumed
    {A_CTRL, 8'h02, 1'b0, 1'b0, 1'b0, 1'b0},  // arm mass
    {A_CMD,  8'hAA, 1'b0, 1'b0, 1'b0, 1'b0},  // R5 debug off
    {A_CMD,  8'hAA, 1'b1, 1'b1, 1'b0, 1'b1},  // R2 / R5 arm kept
    {A_CMD,  8'hAA, 1'b1, 1'b0, 1'b0, 1'b0},  // R6 consumed
    {A_CMD,  8'h55, 1'b1, 1'b0, 1'b0, 1'b0}   // R4 no page write
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_we = 1'b1; sfr_addr = a; sfr_wdata = d;
    @(negedge clk);
    sfr_we = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); flash_done = 1'b1;
    @(negedge clk); flash_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 busy", {7'd0, busy}, 8'd0);
    check("R10 reqs", {6'd0, page_erase_req, mass_erase_req}, 8'd0);
    check("R10 page", {1'b0, erase_page}, 8'd0);
    check("R10 pwe", {7'd0, prog_redirect}, 8'd0);
    wr(A_CMD, 8'h55);
    check("R10 page arm clear", {7'd0, page_erase_req}, 8'd0);

    for (int i = 0; i < NV; i++) begin
      dbg_port_en = VEC[i][3];
      wr(VEC[i][19:12], VEC[i][11:4]);
      check($sformatf("vec%0d page_req R1", i), {7'd0, page_erase_req}, {7'd0, VEC[i][1]});
      check($sformatf("vec%0d mass_req R2", i), {7'd0, mass_erase_req}, {7'd0, VEC[i][0]});
      if (VEC[i][2]) begin
        @(negedge clk);
        check("R1 single cycle", {6'd0, page_erase_req, mass_erase_req}, 8'd0);
        pulse_done();
      end
    end

    // R4 page field: bit 7 ignored
    wr(A_PAGE, 8'hFF);
    check("R4 page field", {1'b0, erase_page}, 8'h7F);
    wr(A_PAGE, 8'h10);
    wr(A_CMD, 8'h55);
    check("R1 page req", {7'd0, page_erase_req}, 8'd1);
    check("R1 page value", {1'b0, erase_page}, 8'h10);
    // R7 busy holds; keys ignored while busy, arm survives
    @(negedge clk);
    check("R7 busy held", {7'd0, busy}, 8'd1);
    dbg_port_en = 1'b1;
    wr(A_CTRL, 8'h02);
    wr(A_CMD, 8'hAA);
    check("R7 key ignored busy", {7'd0, mass_erase_req}, 8'd0);
    pulse_done();
    check("R7 busy cleared", {7'd0, busy}, 8'd0);
    wr(A_CMD, 8'hAA);
    check("R7 arm kept", {7'd0, mass_erase_req}, 8'd1);
    pulse_done();

    // R8 interrupt lock on program-write bit
    irq_global_en = 1'b1;
    wr(A_CTRL, 8'h01);
    check("R8 locked", {7'd0, prog_redirect}, 8'd0);
    irq_global_en = 1'b0;
    wr(A_CTRL, 8'h01);
    check("R8 set", {7'd0, prog_redirect}, 8'd1);
    irq_global_en = 1'b1;
    wr(A_CTRL, 8'h00);
    check("R8 locked clear", {7'd0, prog_redirect}, 8'd1);
    // R9 self-clear after one data-move write
    @(negedge clk); xmove_wr = 1'b1;
    @(negedge clk); xmove_wr = 1'b0;
    check("R9 self clear", {7'd0, prog_redirect}, 8'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule